// File: doc/BRIEF.md
# Cache Tag Directory with Hit Compare

This block is the directory half of a cache. It keeps one tag per cache set, selected by a set index, and each tag carries a valid flag of its own. A write access stores the tag presented on the input at the indexed set and marks that set valid. A compare access looks up the indexed set and, one clock later, reports a hit when the set is valid and its stored tag equals the tag that was presented. A single clear input empties the whole directory in one cycle, so that every later lookup misses until sets are written again.

Every access is a single-cycle request marked by the select input. The block accepts a request on every clock and never stalls, so it has no ready signal and applies no back-pressure. The caller gets the result on the cycle after the request and holds no handshake state. The tag read out on a compare stays on the output until the next compare. The output-enable input forces that output to zero without disturbing what it holds. The default index width is kept small; a full-size directory uses a 13-bit index, giving 8192 sets of 8-bit tags.

Top module: `tag_dir`

## Requirements
- R1: When cs_i=1, we_i=1 and clr_i=0 at a rising clock edge, the tag on tag_i is stored at set idx_i and that set becomes valid.
- R2: When cs_i=1, we_i=0 and clr_i=0 at an edge, match_o is 1 during the following cycle if set idx_i is valid and its stored tag equals tag_i.
- R3: A compare whose presented tag differs from the stored tag of a valid set gives match_o=0 in the following cycle.
- R4: A compare on a set that was never written since the last clear or reset gives match_o=0.
- R5: match_o is 0 in the cycle after any edge at which there was no compare request (cs_i=0, or we_i=1).
- R6: clr_i=1 at one edge invalidates every set at once; every later compare misses until the set is written again.
- R7: When clr_i=1 and a write request meet at the same edge, the clear wins: the set stays invalid, and a compare with that tag misses.
- R8: With oe_i=0, tag_o is 0; with oe_i=1, tag_o shows the stored tag read by the most recent compare, clear or no clear.
- R9: Cycles with no compare request leave the held read tag unchanged.
- R10: A compare issued in the cycle right after a write to the same set sees the new tag and reports a hit.
- R11: While rst_ni is low, match_o and tag_o are 0 and every set is invalid; after reset, a compare on a previously written set misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of every valid flag |
| cs_i | input | 1 | Request strobe; no access happens when low |
| we_i | input | 1 | 1 = write the tag, 0 = compare against it |
| oe_i | input | 1 | Drives the held read tag onto tag_o when high |
| idx_i | input | IDX_W | Set index |
| tag_i | input | TAG_W | Tag to store or to compare |
| tag_o | output | TAG_W | Stored tag from the latest compare, zero when oe_i is low |
| match_o | output | 1 | Hit flag for the compare of the previous cycle |

## Verification
The assertions take the inputs to be known 0/1 values after reset, and they take a write followed by a compare to the same set with the same tag, and no clear in either cycle, as a guaranteed hit. They also assume that tag_o may be checked for stability only while oe_i stays high across the cycle. The stimulus changes inputs only on the falling edge and never leaves them undriven. Whenever it issues a write then a compare back to back, it uses the same index and tag in both. Clears and resets are applied only when no earlier compare result is still waiting to be sampled.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;
  localparam int unsigned DEF_IDX_W = 10;
  localparam int unsigned DEF_TAG_W = 8;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_CMP   = 2'd2,
    ACC_CLEAR = 2'd3
  } acc_e;
endpackage

// File: rtl/tag_dir_store.sv
module tag_dir_store #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] wdata_i,
  output logic [TAG_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/tag_dir_valid.sv
module tag_dir_valid #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             valid_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    logic hit_sel;
    assign hit_sel = set_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q[g] <= 1'b0;
      else if (clr_i)   valid_q[g] <= 1'b0;
      else if (hit_sel) valid_q[g] <= 1'b1;
    end
  end

  assign valid_o = valid_q[idx_i];
endmodule

// File: rtl/tag_dir_cmp.sv
module tag_dir_cmp #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             judge_i,
  input  logic             entry_valid_i,
  input  logic [TAG_W-1:0] stored_i,
  input  logic [TAG_W-1:0] probe_i,
  output logic [TAG_W-1:0] held_o,
  output logic             hit_o
);
  logic             hit_q;
  logic [TAG_W-1:0] held_q;
  logic             same;

  assign same = (stored_i == probe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      held_q <= '0;
    end else begin
      hit_q <= judge_i && entry_valid_i && same;
      if (load_i) held_q <= stored_i;
    end
  end

  assign held_o = held_q;
  assign hit_o  = hit_q;
endmodule

// File: rtl/tag_dir.sv
module tag_dir
  import tag_dir_pkg::*;
#(
  parameter int unsigned IDX_W = DEF_IDX_W,
  parameter int unsigned TAG_W = DEF_TAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic             oe_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             match_o
);
  acc_e             acc;
  logic             do_wr;
  logic             do_cmp;
  logic             do_judge;
  logic             entry_valid;
  logic [TAG_W-1:0] entry_tag;
  logic [TAG_W-1:0] held_tag;

  always_comb begin
    if (clr_i)             acc = ACC_CLEAR;
    else if (!cs_i)        acc = ACC_IDLE;
    else if (we_i)         acc = ACC_WRITE;
    else                   acc = ACC_CMP;
  end

  assign do_wr    = (acc == ACC_WRITE);
  assign do_judge = (acc == ACC_CMP);
  assign do_cmp   = cs_i && !we_i;

  tag_dir_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i   (clk_i),
    .wr_i    (do_wr),
    .idx_i   (idx_i),
    .wdata_i (tag_i),
    .rdata_o (entry_tag)
  );

  tag_dir_valid #(.IDX_W(IDX_W)) u_valid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (acc == ACC_CLEAR),
    .set_i   (do_wr),
    .idx_i   (idx_i),
    .valid_o (entry_valid)
  );

  tag_dir_cmp #(.TAG_W(TAG_W)) u_cmp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (do_cmp),
    .judge_i       (do_judge),
    .entry_valid_i (entry_valid),
    .stored_i      (entry_tag),
    .probe_i       (tag_i),
    .held_o        (held_tag),
    .hit_o         (match_o)
  );

  assign tag_o = oe_i ? held_tag : '0;
endmodule

// File: rtl/tag_dir_chk.sv
module tag_dir_chk #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             cs_i,
  input logic             we_i,
  input logic             oe_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [TAG_W-1:0] tag_i,
  input logic [TAG_W-1:0] tag_o,
  input logic             match_o
);
  AST_HIT_NEEDS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(cs_i && !we_i && !clr_i)); // R5

  AST_WRITE_GIVES_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i) |=> !match_o); // R5

  AST_CLEAR_GIVES_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !match_o); // R6

  AST_OE_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (tag_o == '0)); // R8

  AST_TAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!(cs_i && !we_i)) && oe_i && $past(oe_i)) |-> $stable(tag_o)); // R9

  AST_WRITE_THEN_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_i && we_i && !clr_i) && cs_i && !we_i && !clr_i &&
     (idx_i == $past(idx_i)) && (tag_i == $past(tag_i))) |=> match_o); // R10
endmodule

bind tag_dir tag_dir_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .cs_i    (cs_i),
  .we_i    (we_i),
  .oe_i    (oe_i),
  .idx_i   (idx_i),
  .tag_i   (tag_i),
  .tag_o   (tag_o),
  .match_o (match_o)
);

// File: tb/tag_dir_tb_top.sv
module tag_dir_tb_top;
  localparam int CLK_P = 10;
  localparam int IDX_W = 10;
  localparam int TAG_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clr_i = 1'b0;
  logic             cs_i = 1'b0;
  logic             we_i = 1'b0;
  logic             oe_i = 1'b1;
  logic [IDX_W-1:0] idx_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic [TAG_W-1:0] tag_o;
  logic             match_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    bit               exp_match;
    bit               chk_tag;
    logic [TAG_W-1:0] exp_tag;
    string            req;
  } item_t;

  item_t sb_q[$];

  bit               mv [DEPTH];
  bit               mk [DEPTH];
  logic [TAG_W-1:0] mt [DEPTH];
  logic [TAG_W-1:0] last_tag = '0;
  bit               last_known = 1'b1;

  always #(CLK_P/2) clk_i = ~clk_i;

  tag_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_i), .cs_i (cs_i),
    .we_i (we_i), .oe_i (oe_i), .idx_i (idx_i), .tag_i (tag_i),
    .tag_o (tag_o), .match_o (match_o)
  );

  task automatic check_bit(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_tag(string req, logic [TAG_W-1:0] act, logic [TAG_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s tag_o actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one access per cycle, model updated from the requirements
  task automatic acc(string req, bit cs, bit we, bit clr, bit oe,
                     int idx, logic [TAG_W-1:0] tag);
    item_t it;
    @(negedge clk_i);
    cs_i = cs; we_i = we; clr_i = clr; oe_i = oe;
    idx_i = IDX_W'(idx); tag_i = tag;
    it.exp_match = 1'b0;
    if (cs && !we) begin
      it.exp_match = !clr && mv[idx] && (mt[idx] === tag);
      last_tag   = mt[idx];
      last_known = mk[idx];
    end
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mv[i] = 1'b0;
    end else if (cs && we) begin
      mv[idx] = 1'b1; mt[idx] = tag; mk[idx] = 1'b1;
    end
    it.chk_tag = oe ? last_known : 1'b1;
    it.exp_tag = oe ? last_tag : '0;
    it.req     = req;
    sb_q.push_back(it);
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check_bit(it.req, "match_o", match_o, it.exp_match);
        if (it.chk_tag) check_tag(it.req, tag_o, it.exp_tag);
      end
    end
  end

  task automatic drain();
    acc("R5", 1'b0, 1'b0, 1'b0, 1'b1, 0, '0);
    while (sb_q.size() > 0) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 1'b0; mk[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check_bit("R11", "match_o", match_o, 1'b0);
    check_tag("R11", tag_o, '0);
    rst_ni = 1'b1;

    acc("R1",  1, 1, 0, 1, 5, 8'hA5);
    acc("R10", 1, 0, 0, 1, 5, 8'hA5);
    acc("R3",  1, 0, 0, 1, 5, 8'hA4);
    acc("R4",  1, 0, 0, 1, 7, 8'h00);
    acc("R1",  1, 1, 0, 1, DEPTH-1, 8'h3C);
    acc("R1",  1, 1, 0, 1, 0, 8'hFF);
    acc("R5",  1, 1, 0, 1, 3, 8'h12);
    acc("R2",  1, 0, 0, 1, DEPTH-1, 8'h3C);
    acc("R2",  1, 0, 0, 1, 0, 8'hFF);
    acc("R8",  1, 0, 0, 0, 5, 8'hA5);
    acc("R9",  0, 0, 0, 1, 5, 8'hA5);
    acc("R9",  0, 1, 0, 1, 0, 8'hFF);
    acc("R2",  1, 0, 0, 1, 3, 8'h12);
    acc("R1",  1, 1, 0, 1, 5, 8'h5A);
    acc("R3",  1, 0, 0, 1, 5, 8'hA5);
    acc("R2",  1, 0, 0, 1, 5, 8'h5A);
    drain();

    acc("R6",  0, 0, 1, 1, 0, '0);
    acc("R6",  1, 0, 0, 1, 5, 8'h5A);
    acc("R6",  1, 0, 0, 1, 0, 8'hFF);
    acc("R8",  1, 0, 0, 1, DEPTH-1, 8'h3C);
    acc("R7",  1, 1, 1, 1, 9, 8'h11);
    acc("R7",  1, 0, 0, 1, 9, 8'h11);
    acc("R6",  1, 0, 1, 1, 3, 8'h12);
    acc("R1",  1, 1, 0, 1, 9, 8'h11);
    acc("R2",  1, 0, 0, 1, 9, 8'h11);
    acc("R1",  1, 1, 0, 1, 0, 8'hFF);
    drain();

    // R11: reset mid-run clears flags and outputs
    @(negedge clk_i);
    rst_ni = 1'b0; cs_i = 1'b0; oe_i = 1'b1;
    @(negedge clk_i);
    check_bit("R11", "match_o", match_o, 1'b0);
    check_tag("R11", tag_o, '0);
    for (int i = 0; i < DEPTH; i++) mv[i] = 1'b0;
    last_tag = '0; last_known = 1'b1;
    rst_ni = 1'b1;
    acc("R11", 1, 0, 0, 1, 0, 8'hFF);
    acc("R11", 1, 0, 0, 1, 9, 8'h11);
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule